// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter Bank

This block decides whether a received frame should be kept, based on its 32-bit identifier word. The word packs a standard or extended identifier: the 11-bit base identifier sits in bits 31:21. Bit 20 is the substitute-remote flag and bit 19 is the extension flag. The 18-bit extended identifier occupies bits 18:1, and the remote-request flag is bit 0. Four filters each hold a mask word and a match word in that same layout. A filter hits when the incoming word and the match word agree on every bit that the mask sets.

Software controls the bank through a single register write port. The port writes a 4-bit enable field, or the mask or match word of one filter. A mask or match word may be rewritten only when its filter is disabled and the busy flag is low. Any other write to those words is dropped. Busy rises in the cycle that clears an enable bit and stays high for one more cycle, which lets a comparison already in flight finish. The receive path presents an identifier with a one-cycle strobe. The decision appears, registered, one cycle later with its own valid.

Top module: `id_accept_filter`

## Requirements
- R1: After reset accept_valid and busy are low, all enable bits are clear and every mask and match word is zero.
- R2: accept_valid is high exactly in the cycle after a cycle with id_valid high, and low otherwise; accept is meaningful only then.
- R3: A filter hits when (id_word AND mask) equals (match AND mask); bits with mask 0 do not influence the hit.
- R4: With at least one filter enabled, accept is 1 when any enabled filter hits and 0 when none does.
- R5: With all enable bits clear, every identifier is accepted.
- R6: A disabled filter takes no part in the decision even when its words would hit.
- R7: A write to the mask or match word of a filter whose enable bit is set leaves that word unchanged.
- R8: busy is high in the cycle of an enable-field write that clears a set bit and in the following cycle, and a mask or match write in either cycle is dropped.
- R9: Field layout is honoured: a mask of 0xFFE00000 compares only the 11-bit base identifier in bits 31:21, and bit 0 (remote request) is an ordinary compared bit.
- R10: Writing the enable field (wr_sel 0) without clearing any set bit leaves busy low; mask is wr_sel 1, match is wr_sel 2, selected filter is wr_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 enable field, 1 mask word, 2 match word |
| wr_idx | input | 2 | Filter selected for mask/match writes |
| wr_data | input | 32 | Write data (enable field in bits 3:0) |
| id_valid | input | 1 | Identifier strobe |
| id_word | input | 32 | Packed identifier word |
| accept | output | 1 | Registered keep decision |
| accept_valid | output | 1 | Decision valid, one cycle after id_valid |
| busy | output | 1 | Filter words must not be rewritten |

## Verification
The bench targets masked-out bits. A design that compared them would reject identifiers that differ only in the extended field under a base-identifier mask. It also checks the all-disabled case. A design that ORs only the enabled hits would reject everything there. Protected writes are checked by their effect on later decisions. A design that lets a write through to an enabled filter, or through during the busy tail, changes which identifiers are kept afterwards. The bench also samples busy in the clearing cycle itself and in the cycle after, so a flag that is delayed or too short is caught.

// File: rtl/id_accept_filter.sv
module id_accept_filter #(
  parameter int NFILT = 4,
  parameter int IDW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [$clog2(NFILT)-1:0] wr_idx,
  input  logic [IDW-1:0]           wr_data,
  input  logic                     id_valid,
  input  logic [IDW-1:0]           id_word,
  output logic                     accept,
  output logic                     accept_valid,
  output logic                     busy
);
  localparam logic [1:0] SEL_EN = 2'd0, SEL_MASK = 2'd1, SEL_MATCH = 2'd2;

  logic [NFILT-1:0] en_r;
  logic [IDW-1:0]   mask_r  [NFILT];
  logic [IDW-1:0]   match_r [NFILT];
  logic [NFILT-1:0] hit;
  logic             busy_q;
  logic             clr_now;
  logic             word_ok;

  assign clr_now = wr_en && wr_sel == SEL_EN && |(en_r & ~wr_data[NFILT-1:0]);
  assign busy    = clr_now | busy_q;
  assign word_ok = wr_en && !en_r[wr_idx] && !busy;

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    assign hit[g] = ((id_word ^ match_r[g]) & mask_r[g]) == '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mask_r[g]  <= '0;
        match_r[g] <= '0;
      end else if (word_ok && wr_idx == g) begin
        if (wr_sel == SEL_MASK)  mask_r[g]  <= wr_data;
        if (wr_sel == SEL_MATCH) match_r[g] <= wr_data;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_r         <= '0;
      busy_q       <= 1'b0;
      accept       <= 1'b0;
      accept_valid <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_EN) en_r <= wr_data[NFILT-1:0];
      busy_q       <= clr_now;
      accept_valid <= id_valid;
      if (id_valid) accept <= (en_r == '0) || |(en_r & hit);
    end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> accept_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !accept_valid); // R2
  AST_OPEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && en_r == '0) |=> accept); // R5
  AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> busy); // R8
  AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MASK && en_r[wr_idx]) |=> mask_r[$past(wr_idx)] == $past(mask_r[wr_idx])); // R7
  AST_LOCKED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MATCH && busy) |=> match_r[$past(wr_idx)] == $past(match_r[wr_idx])); // R8
endmodule

// File: tb/id_accept_filter_bench.sv
module id_accept_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam logic [32:0] VEC [NV] = '{
    {32'h2460_0000, 1'b1},
    {32'h247F_FFFF, 1'b1},
    {32'h2480_0000, 1'b0},
    {32'h1234_5679, 1'b1},
    {32'h1234_5678, 1'b0},
    {32'h0008_0000, 1'b0},
    {32'hFFFF_FFFF, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, wr_idx = 0;
  logic [31:0] wr_data = 0, id_word = 0;
  logic id_valid = 0;
  logic accept, accept_valid, busy;
  int applied = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  id_accept_filter u_id_accept_filter (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .id_valid(id_valid), .id_word(id_word),
    .accept(accept), .accept_valid(accept_valid), .busy(busy));

  task automatic check(string req, logic act, logic exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [1:0] idx, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic probe(string req, logic [31:0] w, logic exp);
    @(negedge clk); id_valid = 1; id_word = w;
    @(negedge clk); id_valid = 0;
    check({req, " valid"}, accept_valid, 1'b1);
    check(req, accept, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid", accept_valid, 1'b0);
    check("R1 busy", busy, 1'b0);
    probe("R1 R5 accept-all after reset", 32'h1357_9BDF, 1'b1);
    @(negedge clk);
    check("R2 valid drops", accept_valid, 1'b0);

    wr(2'd1, 2'd0, 32'hFFE0_0000);
    wr(2'd2, 2'd0, 32'h2460_0000);
    wr(2'd1, 2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 2'd1, 32'h1234_5679);
    wr(2'd1, 2'd2, 32'h0008_0000);
    wr(2'd2, 2'd2, 32'h0008_0000);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h3; #1;
    check("R10 set enable no busy", busy, 1'b0);
    @(negedge clk); wr_en = 0;

    for (int i = 0; i < NV; i++)
      probe("R3 R4 R6 R9 table", VEC[i][32:1], VEC[i][0]);

    wr(2'd1, 2'd0, 32'h0);
    probe("R7 mask write to enabled filter dropped", 32'h2480_0000, 1'b0);

    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 32'h2; #1;
    check("R8 busy in clearing cycle", busy, 1'b1);
    @(negedge clk); wr_sel = 1; wr_idx = 0; wr_data = 32'h0; #1;
    check("R8 busy one cycle after", busy, 1'b1);
    @(negedge clk); wr_en = 0; #1;
    check("R8 busy released", busy, 1'b0);
    wr(2'd0, 2'd0, 32'h3);
    probe("R8 write during busy dropped", 32'h2480_0000, 1'b0);

    wr(2'd0, 2'd0, 32'h2);
    @(negedge clk);
    wr(2'd1, 2'd0, 32'h0);
    wr(2'd0, 2'd0, 32'h3);
    probe("R7 write to disabled filter lands", 32'h2480_0000, 1'b1);

    wr(2'd0, 2'd0, 32'h0);
    probe("R5 none enabled", 32'h0000_0001, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule